// File: doc/BRIEF.md
# Core Module System Control Register File

This block is the system control register file of a processor core module. A processor reaches it over a simple word-indexed register bus: an address index, a write enable, write data and a combinational read-data return. It supplies fixed identification and status words. It holds two clock-synthesiser settings that only change while a magic key sits in a lock register. A control word drives an indicator LED and the boot memory remap, and it can request a system reset. Two flag words are changed through separate set and clear addresses.

The block also contains a free-running 32-bit reference counter. It advances at a reference rate that is derived from the system clock by a fractional accumulator. A read-only window onto the bytes of a memory-module presence-detect table shares the register space. The outputs drive the board: a remap enable for the address decoder, an LED drive, and a one-cycle reset request to the reset controller.

Top module: `core_sysctl`

## Requirements
- R1: Index 0 reads the constant 0x411A3001, index 4 reads 0x00100000, and index 1 reads zero. Writes to these indices have no effect.
- R2: The lock register at index 5 keeps only the low 16 bits of a write. It reads as the stored value, with bit 16 also set while the stored value equals the key 0xA05F.
- R3: Writes to the clock word (index 2) and the auxiliary clock word (index 7) update them only while the lock holds 0xA05F. In any other lock state those writes are ignored.
- R4: A write to the control word at index 3 stores only data bits 0 and 2. Writing data bit 3 raises `sys_rst_req` for exactly the one cycle after the write edge. A read of index 3 shows bit 3 as zero.
- R5: `led_on` follows control bit 0. `remap_en` follows control bit 2: when it is 1, boot flash leaves address zero and RAM appears there. Both are 0 after reset.
- R6: The flag word reads at index 12. A write to index 12 ORs the data into it, and a write to index 13 clears the bits that are 1 in the data. The second flag word behaves the same way at indices 14 (read and set) and 15 (clear). Both words are zero after reset.
- R7: Word indices 64 to 95 read a presence-detect byte, zero-extended, whose value is (29*i + 7) mod 256 for word index i. Indices 96 to 127 read zero.
- R8: Index 10 reads a 32-bit counter that is zero at reset. It advances by exactly one on each reference tick. A tick occurs when an accumulator that adds REF_HZ each cycle reaches SYS_HZ, so with the defaults (96 MHz system, 24 MHz reference) the counter advances once every 4 cycles.
- R9: After reset the clock word reads 0x01000048, the auxiliary clock word 0x0007FEFF, the memory configuration word (index 8) 0x00011122 and the init word (index 9) 0x00000112. Indices 8 and 9 take any write in full.
- R10: Every other index, including the voltage words 32 to 35, reads zero, and writes to it change no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word index of the access |
| bus_wr | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| remap_en | output | 1 | 1 = boot flash unmapped, RAM at address zero |
| led_on | output | 1 | Indicator LED drive |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench sweeps all 128 indices after reset and again after all-ones writes to every unimplemented index. A design that decoded an index too widely would then show a changed word or a nonzero read. The lock is tried with near-miss keys, with a key carried in the upper write bits, and after the lock is re-closed. A wrong key compare or a lock that keeps the full write would let the clock words change. The reset request is sampled on the two cycles after the write. A latched bit would hold high for the second cycle, and a stored bit would read back in the control word. The counter is read twice, exactly 400 cycles apart, and the difference must be 100. A divider that is off by one drifts away from that value.

// File: rtl/core_sysctl_pkg.sv
package core_sysctl_pkg;
   localparam int unsigned IX_ID      = 0;
   localparam int unsigned IX_PROC    = 1;
   localparam int unsigned IX_CLK     = 2;
   localparam int unsigned IX_CTRL    = 3;
   localparam int unsigned IX_STAT    = 4;
   localparam int unsigned IX_LOCK    = 5;
   localparam int unsigned IX_AUXCLK  = 7;
   localparam int unsigned IX_MEMCFG  = 8;
   localparam int unsigned IX_INIT    = 9;
   localparam int unsigned IX_REFCNT  = 10;
   localparam int unsigned IX_FLAG0   = 12;  // set/read; clear is +1
   localparam int unsigned IX_FLAG1   = 14;

   localparam logic [31:0] ID_WORD    = 32'h411A_3001;
   localparam logic [31:0] STAT_WORD  = 32'h0010_0000;
   localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

   localparam logic [31:0] RST_CLK    = 32'h0100_0048;
   localparam logic [31:0] RST_AUXCLK = 32'h0007_FEFF;
   localparam logic [31:0] RST_MEMCFG = 32'h0001_1122;
   localparam logic [31:0] RST_INIT   = 32'h0000_0112;

   // presence-detect byte for a given word index
   function automatic logic [7:0] pd_byte(input int unsigned idx);
      pd_byte = 8'((idx * 29 + 7) % 256);
   endfunction
endpackage

// File: rtl/core_sysctl_setclr.sv
module core_sysctl_setclr #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] data,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (set_en) q <= q | data;
      else if (clr_en) q <= q & ~data;
   end

   p_set_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> ((q & $past(data)) == $past(data)));
   p_clr_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> ((q & $past(data)) == '0));
endmodule

// File: rtl/core_sysctl_refcnt.sv
module core_sysctl_refcnt #(
   parameter int unsigned SYS_HZ = 96_000_000,
   parameter int unsigned REF_HZ = 24_000_000,
   parameter int unsigned CNT_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count
);
   localparam int unsigned ACC_W = $clog2(SYS_HZ + REF_HZ) + 1;
   localparam logic [ACC_W-1:0] STEP  = ACC_W'(REF_HZ);
   localparam logic [ACC_W-1:0] LIMIT = ACC_W'(SYS_HZ);

   if (REF_HZ == 0 || REF_HZ > SYS_HZ) begin : g_bad_rate
      $error("reference rate must be nonzero and not above the system rate");
   end

   logic [ACC_W-1:0] acc_q, acc_sum;
   logic             tick;

   always_comb begin
      acc_sum = acc_q + STEP;
      tick    = (acc_sum >= LIMIT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         count <= '0;
      end else begin
         acc_q <= tick ? (acc_sum - LIMIT) : acc_sum;
         if (tick) count <= count + 1'b1;
      end
   end

   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count) |-> (count == $past(count) + 1'b1));
   p_acc_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < LIMIT);
endmodule

// File: rtl/core_sysctl_pdrom.sv
module core_sysctl_pdrom
   import core_sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PD_LO  = 64,
   parameter int unsigned PD_N   = 32,
   parameter int unsigned PD_WIN = 64
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [DATA_W-1:0] data
);
   if (PD_N > PD_WIN || PD_LO + PD_WIN > (1 << ADDR_W)) begin : g_bad_win
      $error("presence-detect window does not fit the address space");
   end

   logic [7:0] rom [PD_N];
   for (genvar k = 0; k < PD_N; k++) begin : g_rom
      assign rom[k] = pd_byte(PD_LO + k);
   end

   int unsigned ix, off;
   always_comb begin
      ix   = int'(addr);
      off  = ix - PD_LO;
      hit  = (ix >= PD_LO) && (ix < PD_LO + PD_WIN);
      data = '0;
      if (hit && off < PD_N) data = DATA_W'(rom[off]);
   end
endmodule

// File: rtl/core_sysctl.sv
module core_sysctl
   import core_sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LOCK_W = 16,
   parameter int unsigned SYS_HZ = 96_000_000,
   parameter int unsigned REF_HZ = 24_000_000,
   parameter int unsigned PD_LO  = 64,
   parameter int unsigned PD_N   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              remap_en,
   output logic              led_on,
   output logic              sys_rst_req
);
   localparam int unsigned N_FLAG = 2;

   if (DATA_W != 32 || LOCK_W != 16 || ADDR_W < 7) begin : g_bad_cfg
      $error("register layout needs 32-bit data, 16-bit lock, 7+ address bits");
   end

   int unsigned ix;
   assign ix = int'(bus_addr);

   function automatic logic wr_at(input int unsigned a, input int unsigned at,
                                  input logic we);
      wr_at = we && (a == at);
   endfunction

   logic [DATA_W-1:0] clk_q, aux_q, memcfg_q, init_q;
   logic [LOCK_W-1:0] lock_q;
   logic              unlocked;
   assign unlocked = (lock_q == UNLOCK_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q       <= RST_CLK;
         aux_q       <= RST_AUXCLK;
         memcfg_q    <= RST_MEMCFG;
         init_q      <= RST_INIT;
         lock_q      <= '0;
         led_on      <= 1'b0;
         remap_en    <= 1'b0;
         sys_rst_req <= 1'b0;
      end else begin
         sys_rst_req <= wr_at(ix, IX_CTRL, bus_wr) && bus_wdata[3];
         if (wr_at(ix, IX_CLK, bus_wr) && unlocked)    clk_q  <= bus_wdata;
         if (wr_at(ix, IX_AUXCLK, bus_wr) && unlocked) aux_q  <= bus_wdata;
         if (wr_at(ix, IX_MEMCFG, bus_wr)) memcfg_q <= bus_wdata;
         if (wr_at(ix, IX_INIT, bus_wr))   init_q   <= bus_wdata;
         if (wr_at(ix, IX_LOCK, bus_wr))   lock_q   <= bus_wdata[LOCK_W-1:0];
         if (wr_at(ix, IX_CTRL, bus_wr)) begin
            led_on   <= bus_wdata[0];
            remap_en <= bus_wdata[2];
         end
      end
   end

   // set/clear flag words, one per generate slot
   logic [DATA_W-1:0] flag_q [N_FLAG];
   for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
      localparam int unsigned BASE = IX_FLAG0 + 2 * g;
      core_sysctl_setclr #(.W(DATA_W)) u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_en (wr_at(ix, BASE, bus_wr)),
         .clr_en (wr_at(ix, BASE + 1, bus_wr)),
         .data   (bus_wdata),
         .q      (flag_q[g])
      );
   end

   logic [DATA_W-1:0] refcnt;
   core_sysctl_refcnt #(.SYS_HZ(SYS_HZ), .REF_HZ(REF_HZ), .CNT_W(DATA_W)) u_refcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .count (refcnt)
   );

   logic              pd_hit;
   logic [DATA_W-1:0] pd_data;
   core_sysctl_pdrom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PD_LO(PD_LO),
                       .PD_N(PD_N), .PD_WIN(2 * PD_N)) u_pdrom (
      .addr (bus_addr),
      .hit  (pd_hit),
      .data (pd_data)
   );

   always_comb begin
      bus_rdata = '0;
      if (pd_hit) bus_rdata = pd_data;
      else begin
         case (ix)
            IX_ID:     bus_rdata = ID_WORD;
            IX_CLK:    bus_rdata = clk_q;
            IX_CTRL:   bus_rdata = DATA_W'({remap_en, 1'b0, led_on});
            IX_STAT:   bus_rdata = STAT_WORD;
            IX_LOCK:   bus_rdata = DATA_W'({unlocked, lock_q});
            IX_AUXCLK: bus_rdata = aux_q;
            IX_MEMCFG: bus_rdata = memcfg_q;
            IX_INIT:   bus_rdata = init_q;
            IX_REFCNT: bus_rdata = refcnt;
            IX_FLAG0:  bus_rdata = flag_q[0];
            IX_FLAG1:  bus_rdata = flag_q[1];
            default:   bus_rdata = '0;
         endcase
      end
   end

   p_clk_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ix == IX_CLK && !unlocked) |=> $stable(clk_q));
   p_aux_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ix == IX_AUXCLK && !unlocked) |=> $stable(aux_q));
   p_rst_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_req) |-> $past(bus_wr && ix == IX_CTRL && bus_wdata[3]));
   p_remap_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(remap_en) |-> $past(bus_wr && ix == IX_CTRL));
   p_led_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(led_on) |-> $past(bus_wr && ix == IX_CTRL));
endmodule

// File: tb/test_core_sysctl.sv
module test_core_sysctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        remap_en, led_on, sys_rst_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // model state
   logic [31:0] m_clk = 32'h0100_0048, m_aux = 32'h0007_FEFF;
   logic [31:0] m_mem = 32'h0001_1122, m_init = 32'h0000_0112;
   logic [31:0] m_f0 = 0, m_f1 = 0;
   logic [15:0] m_lock = 0;
   logic        m_led = 0, m_remap = 0;

   always #2 clk = ~clk;

   core_sysctl i_core_sysctl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .remap_en(remap_en),
      .led_on(led_on), .sys_rst_req(sys_rst_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 7'(a); bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 7'(a); bus_wr = 1'b0;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] expect_at(input int i);
      if (i >= 64 && i < 96) return 32'((i * 29 + 7) % 256);   // R7
      case (i)
         0:  return 32'h411A_3001;                              // R1
         2:  return m_clk;
         3:  return {29'b0, m_remap, 1'b0, m_led};
         4:  return 32'h0010_0000;                              // R1
         5:  return {15'b0, (m_lock == 16'hA05F), m_lock};      // R2
         7:  return m_aux;
         8:  return m_mem;
         9:  return m_init;
         12: return m_f0;
         14: return m_f1;
         default: return 32'h0;                                 // R10
      endcase
   endfunction

   task automatic sweep(input string tag);
      logic [31:0] v;
      for (int i = 0; i < 128; i++) begin
         if (i == 10) continue;
         rd(i, v);
         check($sformatf("%s idx%0d", tag, i), v, expect_at(i));
      end
   endtask

   initial begin
      logic [31:0] v, a, b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 R1 R7 R10 reset sweep
      sweep("R9/R1/R7/R10 reset");
      check("R5 reset led", {31'b0, led_on}, 0);
      check("R5 reset remap", {31'b0, remap_en}, 0);

      // R3 locked writes ignored
      wr(2, 32'hDEAD_BEEF); wr(7, 32'h1234_5678);
      rd(2, v); check("R3 clk locked", v, m_clk);
      rd(7, v); check("R3 aux locked", v, m_aux);
      // R2 near-miss keys and high-bit carry
      wr(5, 32'h0000_A05E); m_lock = 16'hA05E;
      rd(5, v); check("R2 near key", v, {16'h0, m_lock});
      wr(2, 32'h1111_1111);
      rd(2, v); check("R3 near key", v, m_clk);
      wr(5, 32'hFFFF_A05F); m_lock = 16'hA05F;
      rd(5, v); check("R2 unlocked read", v, 32'h0001_A05F);
      wr(2, 32'hCAFE_0001); m_clk = 32'hCAFE_0001;
      wr(7, 32'h0BAD_F00D); m_aux = 32'h0BAD_F00D;
      rd(2, v); check("R3 clk unlocked", v, m_clk);
      rd(7, v); check("R3 aux unlocked", v, m_aux);
      wr(5, 32'h0000_0000); m_lock = 0;
      wr(2, 32'h0); wr(7, 32'h0);
      rd(2, v); check("R3 relocked clk", v, m_clk);
      rd(7, v); check("R3 relocked aux", v, m_aux);

      // R9 memcfg/init writable
      wr(8, 32'hA5A5_5A5A); m_mem = 32'hA5A5_5A5A;
      wr(9, 32'hFFFF_FFFF); m_init = 32'hFFFF_FFFF;
      rd(8, v); check("R9 memcfg write", v, m_mem);
      rd(9, v); check("R9 init write", v, m_init);

      // R4/R5 control
      @(negedge clk);
      bus_addr = 7'd3; bus_wr = 1'b1; bus_wdata = 32'hFFFF_FFFF;
      #1 check("R4 no early rst", {31'b0, sys_rst_req}, 0);
      @(negedge clk); bus_wr = 1'b0;
      check("R4 rst pulse", {31'b0, sys_rst_req}, 1);
      m_led = 1; m_remap = 1;
      @(negedge clk);
      check("R4 rst one cycle", {31'b0, sys_rst_req}, 0);
      rd(3, v); check("R4 ctrl stored bits", v, 32'h5);
      check("R5 led on", {31'b0, led_on}, 1);
      check("R5 remap on", {31'b0, remap_en}, 1);
      wr(3, 32'h0000_0001); m_remap = 0;
      check("R4 no rst without bit3", {31'b0, sys_rst_req}, 0);
      check("R5 remap off", {31'b0, remap_en}, 0);
      check("R5 led kept", {31'b0, led_on}, 1);
      wr(3, 32'h0000_0004); m_led = 0; m_remap = 1;
      check("R5 led off", {31'b0, led_on}, 0);
      check("R5 remap set", {31'b0, remap_en}, 1);

      // R6 set/clear flags
      wr(12, 32'h0000_00F0); wr(12, 32'h0F00_0001); m_f0 = 32'h0F00_00F1;
      rd(12, v); check("R6 flag set or", v, m_f0);
      wr(13, 32'h0300_0011); m_f0 = 32'h0C00_00E0;
      rd(12, v); check("R6 flag clear", v, m_f0);
      rd(13, v); check("R6 clear addr reads 0", v, 0);
      wr(14, 32'h8000_0003); wr(15, 32'h0000_0001); m_f1 = 32'h8000_0002;
      rd(14, v); check("R6 nv flag", v, m_f1);
      rd(12, v); check("R6 flags independent", v, m_f0);

      // R10 writes to unimplemented indices have no effect
      for (int i = 0; i < 128; i++) begin
         if (i inside {2, 3, 5, 7, 8, 9, 12, 13, 14, 15}) continue;
         wr(i, 32'hFFFF_FFFF);
      end
      sweep("R10/R1/R7 after stray writes");
      check("R10 remap untouched", {31'b0, remap_en}, 1);

      // R8 reference counter: 400 cycles -> 100 ticks
      rd(10, a);
      repeat (399) @(negedge clk);
      rd(10, b);
      check("R8 tick rate", b - a, 100);
      rd(10, v);
      check("R8 monotonic step", v - b, 0);
      done = 1;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
   end

   initial begin
      wait (done || $time > 400000);
      #10;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule